// File: doc/BRIEF.md
# Circular Data Address Generator

This block produces memory addresses for one data bus of a DSP core. It holds two banks of register sets. Each set has four index, four modify, four length and four base registers. A request names an index register, a modifier and an addressing mode. The modifier is either one of the modify registers or a signed 8-bit immediate.

- In pre-modify mode the block emits index plus modifier and leaves the index alone.
- In post-modify mode it emits the index, then writes back the modified value.
- In modify-only mode it updates the index and makes no memory access.

Index updates can wrap inside a circular buffer, which is bounded by the base and length registers that carry the same number as the index. An 8-bit page register sits above the 16-bit address to form a 24-bit bus address. An optional mode mirrors the 16 address bits end to end, which produces the access order an FFT needs. A one-cycle pulse swaps the active register set for the shadow set, for fast context switching.

The surrounding core drives register writes through a small write port, issues one request per cycle, and receives the address one clock later.

Top module: `circ_agen`

## Requirements
- R1: After reset every index, modify, length and base register in both sets reads as 0, the page is 0, `addr_valid_o` is low and `addr_o` is 0.
- R2: A pre-modify request (`req_mode_i` = 0) yields `addr_valid_o` high one cycle later with `addr_o[15:0]` = index + modifier, and the index register keeps its value.
- R3: A post-modify request (`req_mode_i` = 1) yields `addr_o[15:0]` = the index before the update one cycle later, and the index register then holds the modified value.
- R4: A modify-only request (`req_mode_i` = 2) updates the index as a post-modify would, keeps `addr_valid_o` low and leaves `addr_o` unchanged. Mode 3 does nothing.
- R5: Any modify register can pair with any index register. The length and base registers used are always those with the same number as the index.
- R6: With length 0 the update is linear and arithmetic is modulo 2^16 (0xFFFE + 5 = 0x0003).
- R7: With a nonzero length L and base B, an index update computes n = I + M. If n ≥ B + L the stored value is n − L; if n < B it is n + L. For B = 0x30, M = 3, L = 8 and I starting at 0x30, successive post-modify addresses are 0x30, 0x33, 0x36, 0x31, 0x34. The pre-modify address is never wrapped.
- R8: When `req_use_imm_i` is 1, `req_imm_i` is sign-extended to 16 bits and used as the modifier (0xFE acts as −2).
- R9: `addr_o[23:16]` is the page register value in the cycle of the request. A page write takes effect for requests in later cycles.
- R10: While `brev_en_i` is high, `addr_o[15:0]` is the computed address with bit j moved to bit 15−j (0x0028 gives 0x1400). Stored index values are never reversed.
- R11: A one-cycle pulse on `bank_swap_i` switches all reads, writes and updates to the other register set from the next cycle on. Both sets keep their contents.
- R12: Register write encoding: `wr_kind_i` 0 = index, 1 = modify, 2 = length, 3 = base. A write lands in the active set and takes priority over a same-cycle update of the same index. A request in the write cycle sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_kind_i | input | 2 | Register kind: 0 index, 1 modify, 2 length, 3 base |
| wr_idx_i | input | 2 | Register number 0..3 |
| wr_data_i | input | 16 | Write data |
| page_wr_i | input | 1 | Page register write strobe |
| page_data_i | input | 8 | New page value |
| bank_swap_i | input | 1 | Pulse to swap the active and shadow register sets |
| brev_en_i | input | 1 | Mirror the 16 output address bits |
| req_valid_i | input | 1 | Request strobe |
| req_mode_i | input | 2 | 0 pre-modify, 1 post-modify, 2 modify-only, 3 none |
| req_idx_i | input | 2 | Index register number |
| req_use_imm_i | input | 1 | Use the immediate instead of a modify register |
| req_midx_i | input | 2 | Modify register number |
| req_imm_i | input | 8 | Signed immediate modifier |
| addr_valid_o | output | 1 | Address strobe, one cycle after an access request |
| addr_o | output | 24 | Page in bits 23:16, generated address in bits 15:0 |

## Verification
The bound checker enforces the following on every cycle:
- the pre-modify address, the post-modify address and the mirrored address, each against the index and modifier seen in the request cycle;
- the page field against the page register at request time;
- the quiet output after modify-only and no-op requests.

The wrap sequences in both directions, linear overflow, immediate sign extension, write-over-update priority and the preservation of both register sets across swaps only show up in the stored index. The bench scenarios therefore expose them through later requests.

// File: rtl/agen_pkg.sv
package agen_pkg;
  typedef enum logic [1:0] {
    MODE_PRE  = 2'd0,
    MODE_POST = 2'd1,
    MODE_MOD  = 2'd2,
    MODE_NOP  = 2'd3
  } agen_mode_e;

  typedef enum logic [1:0] {
    KIND_IDX  = 2'd0,
    KIND_MOD  = 2'd1,
    KIND_LEN  = 2'd2,
    KIND_BASE = 2'd3
  } reg_kind_e;

  localparam int unsigned NUM_KINDS = 4;
  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/agen_regfile.sv
module agen_regfile import agen_pkg::*; #(
  parameter int unsigned AW   = 16,
  parameter int unsigned NREG = 4,
  localparam int unsigned IW  = $clog2(NREG),
  localparam int unsigned SW  = 1 + 2 + IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          swap_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_kind_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          upd_en_i,
  input  logic [IW-1:0] upd_idx_i,
  input  logic [AW-1:0] upd_data_i,
  input  logic [IW-1:0] rd_idx_i,
  input  logic [IW-1:0] rd_midx_i,
  output logic [AW-1:0] rd_i_o,
  output logic [AW-1:0] rd_m_o,
  output logic [AW-1:0] rd_l_o,
  output logic [AW-1:0] rd_b_o,
  output logic          bank_o
);
  logic          bank_q;
  logic [AW-1:0] rd_arr [2**SW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bank_q <= 1'b0;
    else if (swap_i) bank_q <= ~bank_q;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      for (genvar n = 0; n < NREG; n++) begin : g_reg
        logic [AW-1:0] val_q;
        logic          hit_wr, hit_upd;

        assign hit_wr  = wr_en_i && (bank_q == 1'(b)) && (wr_kind_i == 2'(k))
                         && (wr_idx_i == IW'(n));
        // only index registers take updates; write port wins
        assign hit_upd = (k == 0) && upd_en_i && (bank_q == 1'(b))
                         && (upd_idx_i == IW'(n));

        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)      val_q <= '0;
          else if (hit_wr)  val_q <= wr_data_i;
          else if (hit_upd) val_q <= upd_data_i;
        end

        assign rd_arr[{1'(b), 2'(k), IW'(n)}] = val_q;
      end
    end
  end

  assign rd_i_o = rd_arr[{bank_q, KIND_IDX,  rd_idx_i}];
  assign rd_m_o = rd_arr[{bank_q, KIND_MOD,  rd_midx_i}];
  assign rd_l_o = rd_arr[{bank_q, KIND_LEN,  rd_idx_i}];
  assign rd_b_o = rd_arr[{bank_q, KIND_BASE, rd_idx_i}];
  assign bank_o = bank_q;
endmodule

// File: rtl/agen_calc.sv
module agen_calc import agen_pkg::*; #(
  parameter int unsigned AW = 16
) (
  input  agen_mode_e    mode_i,
  input  logic [AW-1:0] idx_i,
  input  logic [AW-1:0] mod_i,
  input  logic [AW-1:0] len_i,
  input  logic [AW-1:0] base_i,
  output logic          acc_o,
  output logic [AW-1:0] addr_o,
  output logic          upd_o,
  output logic [AW-1:0] next_o
);
  logic [AW-1:0] sum, limit, wrapped;

  assign sum   = idx_i + mod_i;
  assign limit = base_i + len_i;

  always_comb begin
    wrapped = sum;
    if (len_i != '0) begin
      if (sum >= limit)      wrapped = sum - len_i;
      else if (sum < base_i) wrapped = sum + len_i;
    end
  end

  always_comb begin
    acc_o  = 1'b0;
    upd_o  = 1'b0;
    addr_o = idx_i;
    next_o = wrapped;
    unique case (mode_i)
      MODE_PRE: begin
        acc_o  = 1'b1;
        addr_o = sum;
      end
      MODE_POST: begin
        acc_o = 1'b1;
        upd_o = 1'b1;
      end
      MODE_MOD: upd_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/agen_out.sv
module agen_out #(
  parameter int unsigned AW        = 16,
  parameter int unsigned PW        = 8,
  parameter bit          BITREV_EN = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            page_wr_i,
  input  logic [PW-1:0]   page_data_i,
  input  logic            brev_i,
  input  logic            acc_i,
  input  logic [AW-1:0]   addr_i,
  output logic [PW-1:0]   page_o,
  output logic            addr_valid_o,
  output logic [PW+AW-1:0] addr_o
);
  logic [PW-1:0]    page_q;
  logic [AW-1:0]    lo;
  logic             valid_q;
  logic [PW+AW-1:0] addr_q;

  if (BITREV_EN) begin : g_brev
    logic [AW-1:0] rev;
    always_comb begin
      for (int j = 0; j < AW; j++) rev[j] = addr_i[AW-1-j];
    end
    assign lo = brev_i ? rev : addr_i;
  end else begin : g_lin
    logic unused_brev;
    assign unused_brev = brev_i;
    assign lo = addr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q  <= '0;
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (page_wr_i) page_q <= page_data_i;
      valid_q <= acc_i;
      if (acc_i) addr_q <= {page_q, lo};
    end
  end

  assign page_o       = page_q;
  assign addr_valid_o = valid_q;
  assign addr_o       = addr_q;
endmodule

// File: rtl/circ_agen.sv
module circ_agen import agen_pkg::*; #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned NREG      = 4,
  parameter int unsigned IMM_W     = 8,
  parameter bit          BITREV_EN = 1'b1,
  localparam int unsigned IW       = $clog2(NREG),
  localparam int unsigned OW       = PAGE_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_kind_i,
  input  logic [IW-1:0]     wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              page_wr_i,
  input  logic [PAGE_W-1:0] page_data_i,
  input  logic              bank_swap_i,
  input  logic              brev_en_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_mode_i,
  input  logic [IW-1:0]     req_idx_i,
  input  logic              req_use_imm_i,
  input  logic [IW-1:0]     req_midx_i,
  input  logic [IMM_W-1:0]  req_imm_i,
  output logic              addr_valid_o,
  output logic [OW-1:0]     addr_o
);
  logic [ADDR_W-1:0] cur_idx, cur_mod, cur_len, cur_base, mod_val;
  logic [ADDR_W-1:0] calc_addr, calc_next;
  logic              calc_acc, calc_upd, bank_q;
  logic [PAGE_W-1:0] page_q;

  assign mod_val = req_use_imm_i
                   ? {{(ADDR_W-IMM_W){req_imm_i[IMM_W-1]}}, req_imm_i}
                   : cur_mod;

  agen_regfile #(.AW(ADDR_W), .NREG(NREG)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .swap_i     (bank_swap_i),
    .wr_en_i    (wr_en_i),
    .wr_kind_i  (wr_kind_i),
    .wr_idx_i   (wr_idx_i),
    .wr_data_i  (wr_data_i),
    .upd_en_i   (req_valid_i && calc_upd),
    .upd_idx_i  (req_idx_i),
    .upd_data_i (calc_next),
    .rd_idx_i   (req_idx_i),
    .rd_midx_i  (req_midx_i),
    .rd_i_o     (cur_idx),
    .rd_m_o     (cur_mod),
    .rd_l_o     (cur_len),
    .rd_b_o     (cur_base),
    .bank_o     (bank_q)
  );

  agen_calc #(.AW(ADDR_W)) u_calc (
    .mode_i (agen_mode_e'(req_mode_i)),
    .idx_i  (cur_idx),
    .mod_i  (mod_val),
    .len_i  (cur_len),
    .base_i (cur_base),
    .acc_o  (calc_acc),
    .addr_o (calc_addr),
    .upd_o  (calc_upd),
    .next_o (calc_next)
  );

  agen_out #(.AW(ADDR_W), .PW(PAGE_W), .BITREV_EN(BITREV_EN)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .page_wr_i    (page_wr_i),
    .page_data_i  (page_data_i),
    .brev_i       (brev_en_i),
    .acc_i        (req_valid_i && calc_acc),
    .addr_i       (calc_addr),
    .page_o       (page_q),
    .addr_valid_o (addr_valid_o),
    .addr_o       (addr_o)
  );
endmodule

// File: rtl/agen_checker.sv
module agen_checker #(
  parameter int unsigned AW = 16,
  parameter int unsigned PW = 8,
  parameter bit          BR = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [1:0]       req_mode_i,
  input logic             brev_en_i,
  input logic [AW-1:0]    cur_idx_i,
  input logic [AW-1:0]    mod_val_i,
  input logic [PW-1:0]    page_i,
  input logic             bank_i,
  input logic             addr_valid_o,
  input logic [PW+AW-1:0] addr_o
);
  logic [AW-1:0] pre_sum, pre_rev;
  logic          is_acc, is_quiet, lin_out;

  assign pre_sum  = cur_idx_i + mod_val_i;
  always_comb begin
    for (int j = 0; j < AW; j++) pre_rev[j] = pre_sum[AW-1-j];
  end
  assign is_acc   = req_valid_i && (req_mode_i == 2'd0 || req_mode_i == 2'd1);
  assign is_quiet = !req_valid_i || req_mode_i == 2'd2 || req_mode_i == 2'd3;
  assign lin_out  = !(BR && brev_en_i);

  a_r2_pre_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_mode_i == 2'd0 && lin_out)
      |=> addr_o[AW-1:0] == $past(pre_sum));

  a_r3_post_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_mode_i == 2'd1 && lin_out)
      |=> addr_o[AW-1:0] == $past(cur_idx_i));

  a_r4_modonly_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_quiet |=> (!addr_valid_o && $stable(addr_o)));

  a_r9_page_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_acc |=> (addr_valid_o && addr_o[PW+AW-1:AW] == $past(page_i)));

  a_r10_mirror: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_mode_i == 2'd0 && BR && brev_en_i)
      |=> addr_o[AW-1:0] == $past(pre_rev));

  logic unused_bank;
  assign unused_bank = bank_i;
endmodule

bind circ_agen agen_checker #(.AW(ADDR_W), .PW(PAGE_W), .BR(BITREV_EN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_mode_i   (req_mode_i),
  .brev_en_i    (brev_en_i),
  .cur_idx_i    (cur_idx),
  .mod_val_i    (mod_val),
  .page_i       (page_q),
  .bank_i       (bank_q),
  .addr_valid_o (addr_valid_o),
  .addr_o       (addr_o)
);

// File: tb/tb_circ_agen.sv
`timescale 1ns/1ps
module tb_circ_agen;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_en = 0, page_wr = 0, bank_swap = 0, brev_en = 0;
  logic        req_valid = 0, req_use_imm = 0;
  logic [1:0]  wr_kind = 0, wr_idx = 0, req_mode = 0, req_idx = 0, req_midx = 0;
  logic [15:0] wr_data = 0;
  logic [7:0]  page_data = 0, req_imm = 0;
  logic        addr_valid;
  logic [23:0] addr;

  always #2.5 clk = ~clk;

  circ_agen dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_kind_i(wr_kind), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .page_wr_i(page_wr), .page_data_i(page_data),
    .bank_swap_i(bank_swap), .brev_en_i(brev_en),
    .req_valid_i(req_valid), .req_mode_i(req_mode), .req_idx_i(req_idx),
    .req_use_imm_i(req_use_imm), .req_midx_i(req_midx), .req_imm_i(req_imm),
    .addr_valid_o(addr_valid), .addr_o(addr)
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];
  logic [23:0] last_exp = '0;

  function automatic logic [15:0] mirror16(input logic [15:0] a);
    logic [15:0] r;
    for (int j = 0; j < 16; j++) r[j] = a[15-j];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // monitor: pops the scoreboard on every address strobe
  always @(negedge clk) begin
    if (rst_ni && addr_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R4: unexpected strobe actual 0x%06h expected none", addr);
      end else begin
        logic [23:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {8'h0, addr}, {8'h0, e});
      end
    end
  end

  task automatic wr(input logic [1:0] k, input logic [1:0] i, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_kind = k; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic req(input logic [1:0] m, input logic [1:0] i, input logic ui,
                     input logic [1:0] mi, input logic [7:0] imm,
                     input logic [23:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1; req_mode = m; req_idx = i; req_use_imm = ui; req_midx = mi; req_imm = imm;
    if (m < 2) begin
      exp_q.push_back(exp); tag_q.push_back(tag); last_exp = exp;
    end
    @(negedge clk);
    req_valid = 0;
    if (m >= 2) check(tag, {7'h0, addr_valid, addr}, {8'h0, last_exp});
  endtask

  task automatic swap();
    @(negedge clk); bank_swap = 1;
    @(negedge clk); bank_swap = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset strobe", {31'h0, addr_valid}, 32'h0);
    check("R1 reset addr", {8'h0, addr}, 32'h0);
    rst_ni = 1;
    req(0, 2, 0, 2, 0, 24'h000000, "R1 regs zero");

    // basic modes
    wr(0, 0, 16'h0100); wr(1, 1, 16'h0004);
    req(0, 0, 0, 1, 0, 24'h000104, "R2 pre I0+M1");
    req(1, 0, 0, 1, 0, 24'h000100, "R2 index unchanged / R3 post");
    req(0, 0, 1, 0, 8'h00, 24'h000104, "R3 index updated");
    req(0, 0, 1, 0, 8'hFE, 24'h000102, "R8 imm -2");
    req(1, 0, 1, 0, 8'hF0, 24'h000104, "R8 post imm -16");
    req(0, 0, 1, 0, 8'h00, 24'h0000F4, "R8 after -16");
    req(2, 0, 0, 1, 0, 24'h0, "R4 modify-only quiet");
    req(0, 0, 1, 0, 8'h00, 24'h0000F8, "R4 index moved");
    req(3, 0, 0, 1, 0, 24'h0, "R4 nop quiet");
    req(0, 0, 1, 0, 8'h00, 24'h0000F8, "R4 nop no update");

    // circular buffer
    wr(0, 2, 16'h0030); wr(3, 2, 16'h0030); wr(2, 2, 16'h0008); wr(1, 3, 16'h0003);
    req(1, 2, 0, 3, 0, 24'h000030, "R7 seq0");
    req(1, 2, 0, 3, 0, 24'h000033, "R7 seq1");
    req(1, 2, 0, 3, 0, 24'h000036, "R7 seq2");
    req(1, 2, 0, 3, 0, 24'h000031, "R7 seq3");
    req(1, 2, 0, 3, 0, 24'h000034, "R7 seq4");
    wr(1, 0, 16'hFFFD);
    req(1, 2, 0, 0, 0, 24'h000037, "R7 down0");
    req(1, 2, 0, 0, 0, 24'h000034, "R7 down1");
    req(1, 2, 0, 0, 0, 24'h000031, "R7 down2");
    req(0, 2, 1, 0, 8'h00, 24'h000036, "R7 lower wrap");
    req(0, 2, 0, 3, 0, 24'h000039, "R7 pre not wrapped");
    req(2, 2, 0, 3, 0, 24'h0, "R7 modify-only quiet");
    req(0, 2, 1, 0, 8'h00, 24'h000031, "R7 modify-only wraps");
    req(0, 0, 0, 3, 0, 24'h0000FB, "R5 M3 with I0 linear");

    // linear overflow
    wr(0, 1, 16'hFFFE); wr(1, 2, 16'h0005);
    req(1, 1, 0, 2, 0, 24'h00FFFE, "R6 post at top");
    req(0, 1, 1, 0, 8'h00, 24'h000003, "R6 mod 2^16");

    // page: write in the request cycle uses the old page
    @(negedge clk);
    page_wr = 1; page_data = 8'hA5;
    req_valid = 1; req_mode = 0; req_idx = 1; req_use_imm = 1; req_imm = 0;
    exp_q.push_back(24'h000003); tag_q.push_back("R9 old page"); last_exp = 24'h000003;
    @(negedge clk);
    page_wr = 0; req_valid = 0;
    req(0, 1, 1, 0, 8'h00, 24'hA50003, "R9 new page");

    // mirrored output
    wr(0, 3, 16'h0028);
    brev_en = 1;
    req(0, 3, 1, 0, 8'h00, {8'hA5, mirror16(16'h0028)}, "R10 mirror 0x28");
    req(1, 3, 1, 0, 8'h01, {8'hA5, mirror16(16'h0028)}, "R10 post mirror");
    req(0, 3, 1, 0, 8'h00, {8'hA5, mirror16(16'h0029)}, "R10 mirror 0x29");
    brev_en = 0;
    req(0, 3, 1, 0, 8'h00, 24'hA50029, "R10 index not mirrored");

    // bank swap
    swap();
    req(0, 0, 1, 0, 8'h00, 24'hA50000, "R11 shadow zero");
    wr(0, 0, 16'h0555);
    swap();
    req(0, 0, 1, 0, 8'h00, 24'hA500F8, "R11 primary kept");
    swap();
    req(0, 0, 1, 0, 8'h00, 24'hA50555, "R11 shadow kept");

    // write beats same-cycle update
    @(negedge clk);
    wr_en = 1; wr_kind = 0; wr_idx = 1; wr_data = 16'h0200;
    req_valid = 1; req_mode = 1; req_idx = 1; req_use_imm = 1; req_imm = 8'h04;
    exp_q.push_back(24'hA50000); tag_q.push_back("R12 old value"); last_exp = 24'hA50000;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    req(0, 1, 1, 0, 8'h00, 24'hA50200, "R12 write wins");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule